// File: doc/BRIEF.md
# Two-Wire Slave Address and Data Unit

This unit is the byte datapath and address recogniser that sits between a bit-level two-wire bus engine and a CPU register port. A single 8-bit data register serves as both the CPU-visible data register and the bus shift register. On each bit strobe, while the interrupt flag is clear, it moves its top bit out towards the bus and takes the sampled SDA bit in at the bottom. The CPU port also reaches an own-address register, which holds the 7-bit slave address together with a general-call enable, and an address-mask register.

The bus engine marks the start of an address byte and later signals that the byte is complete. At that point the received byte is compared with the own address. The comparison skips every bit whose mask bit is set and always skips the direction bit. If general calls are enabled, an all-zero byte also counts as a match. A match raises the interrupt flag and reports the direction bit and a general-call status, so the engine can choose between slave transmit and slave receive. Data bytes completed after a match also raise the flag.

While the flag is set, shifting stops and the data register changes only through a CPU write. The CPU clears the flag by pulsing a clear input. When arbitration is lost, the flag is raised and the partly shifted byte is left as it is.

Top module: `twb_slave_unit`

## Requirements
- R1: After reset the data register reads 0xFF, the own-address register reads 0xFE, the mask register reads 0x00, and irq_flag, addr_match, gc_match and rw_bit are all 0.
- R2: While irq_flag is 0, each bit_strobe cycle loads data with {data[6:0], sda_in}. sda_out always equals data bit 7, so bytes go out and come in MSB first.
- R3: While irq_flag is 1, bit_strobe has no effect on the data register.
- R4: A CPU write with reg_sel=0 (data) takes effect only while irq_flag is 1. While irq_flag is 0 the write is ignored.
- R5: reg_sel=1 selects the own-address register: bits 7:1 hold the slave address and bit 0 is the general-call enable. All 8 bits are writable and readable.
- R6: reg_sel=2 selects the mask register, of which bits 7:1 are writable. Bit 0 always reads 0. reg_sel=3 reads 0x00.
- R7: On byte_done after addr_start, the byte matches when, for every bit in 7:1, the received bit equals the own-address bit or the mask bit is 1. Bit 0 is ignored. On a match, irq_flag, addr_match and rw_bit (= received bit 0) are set one cycle later.
- R8: An address byte that does not match leaves irq_flag at 0 and sets addr_match to 0.
- R9: A received byte of 0x00 matches only when the general-call enable is 1, in which case gc_match is also set to 1. With the enable at 0 it does not match.
- R10: byte_done outside an address byte sets irq_flag only if the most recent address byte matched.
- R11: A flag_clr pulse clears irq_flag one cycle later, after which shifting resumes.
- R12: arb_lost while irq_flag is 0 sets irq_flag and leaves the bits already shifted into the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 own address, 2 mask, 3 none |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data for reg_sel (combinational) |
| flag_clr | input | 1 | Pulse to clear irq_flag |
| bit_strobe | input | 1 | One bus bit time: shift one bit in and out |
| sda_in | input | 1 | Sampled SDA bit |
| sda_out | output | 1 | Bit to place on SDA (data register MSB) |
| addr_start | input | 1 | The next byte is an address byte |
| byte_done | input | 1 | Eight bits have been shifted |
| arb_lost | input | 1 | Arbitration lost during this byte |
| irq_flag | output | 1 | Interrupt request flag |
| addr_match | output | 1 | Last address byte matched |
| gc_match | output | 1 | Last address byte was an enabled general call |
| rw_bit | output | 1 | Direction bit of the last matched address |

## Verification
All state lives in registers that load on the same edge that samples the stimulus, so every flag, status and data result is due exactly one cycle after its strobe. sda_out and reg_rdata are combinational on that state. The bench drives each strobe on a falling edge and removes it on the next falling edge, which puts exactly one rising edge inside the pulse. It then samples on that falling edge, or a short delay after changing reg_sel, never at a rising edge. Expected data values come from a shift model kept in the bench, and match outcomes come from the masked-compare rule applied by hand to each chosen address.

// File: rtl/twb_pkg.sv
package twb_pkg;
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_OWN  = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } twb_sel_e;
endpackage

// File: rtl/twb_data_sreg.sv
module twb_data_sreg #(
   parameter int           W         = 8,
   parameter logic [W-1:0] RST_VALUE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         ser_in,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] data_q,
   output logic         ser_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= RST_VALUE;
      else if (load_en)
         data_q <= load_val;
      else if (shift_en)
         data_q <= {data_q[W-2:0], ser_in};
   end

   assign ser_out = data_q[W-1];
endmodule

// File: rtl/twb_cfg_regs.sv
module twb_cfg_regs #(
   parameter int           W         = 8,
   parameter bit           MASK_EN   = 1'b1,
   parameter logic [W-1:0] OWN_RESET = {{(W-1){1'b1}}, 1'b0}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_own,
   input  logic         wr_mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] own_q,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_q <= OWN_RESET;
      else if (wr_own)
         own_q <= wdata;
   end

   generate
      if (MASK_EN) begin : g_mask
         logic [W-2:0] mask_hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_hi_q <= '0;
            else if (wr_mask)
               mask_hi_q <= wdata[W-1:1];
         end
         assign mask_q = {mask_hi_q, 1'b0};
      end else begin : g_nomask
         assign mask_q = '0;
      end
   endgenerate
endmodule

// File: rtl/twb_addr_match.sv
module twb_addr_match #(
   parameter int W     = 8,
   parameter bit GC_EN = 1'b1
) (
   input  logic [W-1:0] rx_byte,
   input  logic [W-1:0] own_reg,
   input  logic [W-1:0] mask_reg,
   output logic         own_hit,
   output logic         gc_hit
);
   logic [W-2:0] bit_ok;

   generate
      for (genvar i = 1; i < W; i++) begin : g_bit
         assign bit_ok[i-1] = (rx_byte[i] == own_reg[i]) | mask_reg[i];
      end
   endgenerate

   assign own_hit = &bit_ok;

   generate
      if (GC_EN) begin : g_gc
         assign gc_hit = own_reg[0] & (rx_byte == '0);
      end else begin : g_nogc
         assign gc_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/twb_slave_unit.sv
module twb_slave_unit
   import twb_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter bit MASK_EN = 1'b1,
   parameter bit GC_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W:0]   reg_wdata,
   output logic [ADDR_W:0]   reg_rdata,
   input  logic              flag_clr,
   input  logic              bit_strobe,
   input  logic              sda_in,
   output logic              sda_out,
   input  logic              addr_start,
   input  logic              byte_done,
   input  logic              arb_lost,
   output logic              irq_flag,
   output logic              addr_match,
   output logic              gc_match,
   output logic              rw_bit
);
   localparam int           BW        = ADDR_W + 1;
   localparam logic [BW-1:0] DATA_RST = '1;
   localparam logic [BW-1:0] OWN_RST  = {{ADDR_W{1'b1}}, 1'b0};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("twb_slave_unit: ADDR_W must be at least 2");
      end
   endgenerate

   twb_sel_e sel;
   assign sel = twb_sel_e'(reg_sel);

   logic           flag_q, in_addr_q, addressed_q;
   logic           match_q, gc_q, rw_q;
   logic [BW-1:0]  data_q, own_q, mask_q;
   logic           own_hit, gc_hit, any_hit;
   logic           shift_en, load_en;

   assign shift_en = bit_strobe & ~flag_q;
   assign load_en  = reg_wr_en & (sel == SEL_DATA) & flag_q;

   twb_data_sreg #(.W(BW), .RST_VALUE(DATA_RST)) u_sreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .ser_in   (sda_in),
      .load_en  (load_en),
      .load_val (reg_wdata),
      .data_q   (data_q),
      .ser_out  (sda_out)
   );

   twb_cfg_regs #(.W(BW), .MASK_EN(MASK_EN), .OWN_RESET(OWN_RST)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_own  (reg_wr_en & (sel == SEL_OWN)),
      .wr_mask (reg_wr_en & (sel == SEL_MASK)),
      .wdata   (reg_wdata),
      .own_q   (own_q),
      .mask_q  (mask_q)
   );

   twb_addr_match #(.W(BW), .GC_EN(GC_EN)) u_cmp (
      .rx_byte  (data_q),
      .own_reg  (own_q),
      .mask_reg (mask_q),
      .own_hit  (own_hit),
      .gc_hit   (gc_hit)
   );

   assign any_hit = own_hit | gc_hit;

   // Interrupt flag: set by the bus side only while clear, cleared by the CPU only while set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (flag_q) begin
         if (flag_clr) flag_q <= 1'b0;
      end else if (arb_lost)
         flag_q <= 1'b1;
      else if (byte_done)
         flag_q <= in_addr_q ? any_hit : addressed_q;
   end

   // Address phase tracking and match status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_addr_q   <= 1'b0;
         addressed_q <= 1'b0;
         match_q     <= 1'b0;
         gc_q        <= 1'b0;
         rw_q        <= 1'b0;
      end else if (addr_start) begin
         in_addr_q   <= 1'b1;
         addressed_q <= 1'b0;
      end else if (byte_done && !flag_q && in_addr_q) begin
         in_addr_q   <= 1'b0;
         addressed_q <= any_hit;
         match_q     <= any_hit;
         gc_q        <= gc_hit;
         if (any_hit) rw_q <= data_q[0];
      end
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: reg_rdata = data_q;
         SEL_OWN:  reg_rdata = own_q;
         SEL_MASK: reg_rdata = mask_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_flag   = flag_q;
   assign addr_match = match_q;
   assign gc_match   = gc_q;
   assign rw_bit     = rw_q;
endmodule

// File: rtl/twb_slave_checker.sv
module twb_slave_checker #(
   parameter int BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_strobe,
   input logic          sda_in,
   input logic          reg_wr_en,
   input logic [1:0]    reg_sel,
   input logic [BW-1:0] reg_rdata,
   input logic [BW-1:0] data_q,
   input logic          irq_flag,
   input logic          flag_clr,
   input logic          arb_lost,
   input logic          gc_match,
   input logic          addr_match,
   input logic          sda_out
);
   logic wr_data;
   assign wr_data = reg_wr_en && (reg_sel == 2'd0);

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && !irq_flag && !wr_data) |=> (data_q == {$past(data_q[BW-2:0]), $past(sda_in)}));

   p_msb_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sda_out == data_q[BW-1]);

   p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !wr_data) |=> $stable(data_q));

   p_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag && !bit_strobe && wr_data) |=> $stable(data_q));

   p_mask_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2) |-> (reg_rdata[0] == 1'b0));

   p_gc_implies_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gc_match |-> addr_match);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && flag_clr) |=> !irq_flag);

   p_arb_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !irq_flag && !bit_strobe) |=> (irq_flag && $stable(data_q)));
endmodule

bind twb_slave_unit twb_slave_checker #(.BW(ADDR_W + 1)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_strobe (bit_strobe),
   .sda_in     (sda_in),
   .reg_wr_en  (reg_wr_en),
   .reg_sel    (reg_sel),
   .reg_rdata  (reg_rdata),
   .data_q     (data_q),
   .irq_flag   (irq_flag),
   .flag_clr   (flag_clr),
   .arb_lost   (arb_lost),
   .gc_match   (gc_match),
   .addr_match (addr_match),
   .sda_out    (sda_out)
);

// File: tb/sim_twb_slave_unit.sv
module sim_twb_slave_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       flag_clr = 1'b0, bit_strobe = 1'b0, sda_in = 1'b0;
   logic       sda_out, addr_start = 1'b0, byte_done = 1'b0, arb_lost = 1'b0;
   logic       irq_flag, addr_match, gc_match, rw_bit;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   twb_slave_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
      .bit_strobe(bit_strobe), .sda_in(sda_in), .sda_out(sda_out),
      .addr_start(addr_start), .byte_done(byte_done), .arb_lost(arb_lost),
      .irq_flag(irq_flag), .addr_match(addr_match), .gc_match(gc_match),
      .rw_bit(rw_bit)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: act=0x%02h exp=0x%02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic cpu_wr(input logic [1:0] s, input logic [7:0] v);
      reg_sel = s; reg_wdata = v; reg_wr_en = 1'b1;
      tick();
      reg_wr_en = 1'b0;
   endtask

   task automatic shift_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_in = b[i]; bit_strobe = 1'b1;
         tick();
      end
      bit_strobe = 1'b0;
   endtask

   task automatic pulse_start();  addr_start = 1'b1; tick(); addr_start = 1'b0; endtask
   task automatic pulse_done();   byte_done  = 1'b1; tick(); byte_done  = 1'b0; endtask
   task automatic pulse_clr();    flag_clr   = 1'b1; tick(); flag_clr   = 1'b0; endtask

   task automatic addr_byte(input logic [7:0] b);
      pulse_start();
      shift_byte(b);
      pulse_done();
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd0, v); chk("R1 data reset", v, 8'hFF);
      rd(2'd1, v); chk("R1 own reset", v, 8'hFE);
      rd(2'd2, v); chk("R1 mask reset", v, 8'h00);
      chk("R1 flags reset", {4'h0, irq_flag, addr_match, gc_match, rw_bit}, 8'h00);
   endtask

   task automatic t_config();
      logic [7:0] v;
      cpu_wr(2'd1, 8'hA4); rd(2'd1, v); chk("R5 own write", v, 8'hA4);
      cpu_wr(2'd2, 8'hFF); rd(2'd2, v); chk("R6 mask bit0 zero", v, 8'hFE);
      rd(2'd3, v); chk("R6 unused select", v, 8'h00);
      cpu_wr(2'd2, 8'h00);
      cpu_wr(2'd0, 8'h3C); rd(2'd0, v); chk("R4 write ignored when flag clear", v, 8'hFF);
   endtask

   task automatic t_addr_match();
      logic [7:0] v;
      pulse_start();
      shift_byte(8'hA5);
      rd(2'd0, v); chk("R2 shifted byte", v, 8'hA5);
      chk("R2 sda_out msb", {7'h0, sda_out}, 8'h01);
      chk("R7 no flag before done", {7'h0, irq_flag}, 8'h00);
      pulse_done();
      chk("R7 match flags", {5'h0, irq_flag, addr_match, rw_bit}, 8'h07);
      chk("R9 gc clear on own match", {7'h0, gc_match}, 8'h00);
   endtask

   task automatic t_hold_and_load();
      logic [7:0] v;
      shift_byte(8'h00);
      rd(2'd0, v); chk("R3 data frozen under flag", v, 8'hA5);
      cpu_wr(2'd0, 8'h3C); rd(2'd0, v); chk("R4 write accepted under flag", v, 8'h3C);
      chk("R2 sda_out after load", {7'h0, sda_out}, 8'h00);
      pulse_clr();
      chk("R11 flag cleared", {7'h0, irq_flag}, 8'h00);
      shift_byte(8'h96);
      rd(2'd0, v); chk("R11 shifting resumes", v, 8'h96);
      pulse_done();
      chk("R10 data byte flag when addressed", {7'h0, irq_flag}, 8'h01);
      pulse_clr();
   endtask

   task automatic t_mismatch();
      addr_byte(8'hB4);
      chk("R8 mismatch flags", {6'h0, irq_flag, addr_match}, 8'h00);
      shift_byte(8'h11);
      pulse_done();
      chk("R10 no flag when not addressed", {7'h0, irq_flag}, 8'h00);
   endtask

   task automatic t_masked();
      cpu_wr(2'd2, 8'h18);
      addr_byte(8'hBC);
      chk("R7 masked match", {5'h0, irq_flag, addr_match, rw_bit}, 8'h06);
      pulse_clr();
      addr_byte(8'hBD ^ 8'h40);
      chk("R8 unmasked bit differs", {6'h0, irq_flag, addr_match}, 8'h00);
      cpu_wr(2'd2, 8'h00);
   endtask

   task automatic t_general_call();
      addr_byte(8'h00);
      chk("R9 gc disabled", {5'h0, irq_flag, addr_match, gc_match}, 8'h00);
      cpu_wr(2'd1, 8'hA5);
      addr_byte(8'h00);
      chk("R9 gc enabled", {5'h0, irq_flag, addr_match, gc_match}, 8'h07);
      pulse_clr();
   endtask

   task automatic t_arb_lost();
      logic [7:0] v;
      exp_data = 8'h00;
      for (int i = 0; i < 3; i++) begin
         sda_in = ~i[0]; bit_strobe = 1'b1;
         exp_data = {exp_data[6:0], ~i[0]};
         tick();
      end
      bit_strobe = 1'b0;
      arb_lost = 1'b1; tick(); arb_lost = 1'b0;
      chk("R12 flag on arbitration loss", {7'h0, irq_flag}, 8'h01);
      rd(2'd0, v); chk("R12 partial byte kept", v, exp_data);
      pulse_clr();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL WDOG: run hung act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_config();
      t_addr_match();
      t_hold_and_load();
      t_mismatch();
      t_masked();
      t_general_call();
      t_arb_lost();
      repeat (2) tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule